// File: doc/BRIEF.md
# Duplex Controller Fault Recovery Engine

This block supervises a pair of identical controller channels that run in lockstep. Each channel presents a control word for the actuators, a heartbeat that must keep toggling, and an alarm that flags a functional-interrupt fault. The engine forwards one channel's control word to the actuator port and the same channel's heartbeat to an upstream supervisor. It also watches for three kinds of trouble: a raised alarm, a control-word disagreement, and a heartbeat that has stopped.

A raised alarm earns that channel a full reconfiguration request. A disagreement that lasts for two cycles, with exactly one heartbeat dead, is blamed on the silent channel, and that channel gets a partial reconfiguration request. While the faulty channel is rebuilt, the other channel drives both outputs. When the rebuild reports completion, the engine watches the channel for a fixed settle window. If the channel is clean at the end of that window, duplex operation resumes. If it is not, the channel is declared lost for good and the engine runs on the survivor alone. Only one fault at a time is tolerated. Any fault on the sole working channel ends in a sticky workcell-failure indication.

Top module: `dual_channel_recovery`

## Requirements
- R1: After reset, both channel codes read healthy (0), no request is asserted, `cell_fail` is low, and the outputs forward channel 0.
- R2: In duplex operation, `act_word` equals channel 0's word and `sup_beat` equals channel 0's heartbeat in the same cycle. While a channel is recovering or lost, both outputs follow the other channel.
- R3: In duplex operation, an alarm on a channel produces a one-cycle `full_req` pulse for that channel on the next clock edge. From that edge on, the channel's code reads 2 (full recovery).
- R4: A heartbeat is dead once WDOG_TIMEOUT consecutive clock edges pass without a change in its sampled value. A word mismatch present on two consecutive cycles, while exactly one heartbeat is dead, produces a one-cycle `part_req` pulse to the dead channel, and that channel's code reads 1. A mismatch lasting a single cycle is ignored.
- R5: A confirmed mismatch while both heartbeats are alive causes no request and no change of code.
- R6: An alarm takes priority over a confirmed mismatch in the same cycle. When both alarms rise in the same cycle, channel 0 is served first.
- R7: After the recovering channel's `rcfg_done`, the engine waits SETTLE_CYC cycles. If the channel's heartbeat is then alive, its alarm is low and the words agree, both codes return to 0.
- R8: A channel that fails the settle check reads 3 (lost) from then on. Later alarms or mismatches never produce another request for it.
- R9: An alarm or dead heartbeat on the only working channel, or both heartbeats dead in duplex, raises `cell_fail` on the next edge. `cell_fail` then stays high until reset, with both codes at 3 and `act_word` and `sup_beat` at 0.
- R10: Requests are single-cycle pulses, and at most one of the four request bits is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_word | input | 2*WORD_W | Control word of each channel, index 0 and 1 |
| ch_beat | input | 2 | Heartbeat of each channel |
| ch_alarm | input | 2 | Functional-interrupt alarm of each channel |
| rcfg_done | input | 2 | Reconfiguration finished, per channel |
| act_word | output | WORD_W | Control word forwarded to the actuators |
| sup_beat | output | 1 | Heartbeat forwarded to the supervisor |
| part_req | output | 2 | Partial reconfiguration request pulse, per channel |
| full_req | output | 2 | Full reconfiguration request pulse, per channel |
| ch_state | output | 4 | Two-bit code per channel: 0 healthy, 1 partial, 2 full, 3 lost |
| cell_fail | output | 1 | Workcell failure, sticky |

## Verification
An alarm and a confirmed control-word mismatch can land in the same cycle. In that case the full and partial decisions compete for the same transition. The bench provokes this by stopping channel 0's heartbeat, holding a mismatch for two cycles and raising channel 0's alarm in the second of them. It then expects only a full request and code 2 for channel 0. It also raises both alarms in one cycle, expects channel 0 alone to be served, and compares every output against a behavioural model on each clock.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  typedef enum logic [1:0] {
    CH_OK   = 2'd0,
    CH_PART = 2'd1,
    CH_FULL = 2'd2,
    CH_LOST = 2'd3
  } ch_code_t;

  typedef enum logic [2:0] {
    M_DUPLEX  = 3'd0,
    M_RECOV   = 3'd1,
    M_SETTLE  = 3'd2,
    M_SIMPLEX = 3'd3,
    M_FAILED  = 3'd4
  } mode_t;

  // code shown for channel idx given the engine mode
  function automatic ch_code_t code_for(mode_t m, logic idx, logic fault_ch, logic full_kind);
    ch_code_t c;
    c = CH_OK;
    case (m)
      M_RECOV, M_SETTLE: if (idx == fault_ch) c = full_kind ? CH_FULL : CH_PART;
      M_SIMPLEX:         if (idx == fault_ch) c = CH_LOST;
      M_FAILED:          c = CH_LOST;
      default:           c = CH_OK;
    endcase
    return c;
  endfunction

  // saturating silence counter step
  function automatic int unsigned silence_next(int unsigned cnt, logic toggled, int unsigned limit);
    if (toggled) return 0;
    if (cnt < limit) return cnt + 1;
    return cnt;
  endfunction

endpackage

// File: rtl/dcr_beat_watch.sv
module dcr_beat_watch
  import dcr_pkg::*;
#(
  parameter int WDOG_TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  output logic dead
);
  localparam int CNT_W = $clog2(WDOG_TIMEOUT + 1);

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             toggled;

  assign toggled = beat ^ prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= beat;
      cnt_q  <= CNT_W'(silence_next(int'(cnt_q), toggled, WDOG_TIMEOUT));
    end
  end

  assign dead = (int'(cnt_q) == WDOG_TIMEOUT);
endmodule

// File: rtl/dcr_skew_filter.sv
module dcr_skew_filter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output logic              differ,
  output logic              confirmed
);
  logic differ_q;

  assign differ = (word_a != word_b);

  always_ff @(posedge clk) begin
    if (!rst_n) differ_q <= 1'b0;
    else        differ_q <= differ;
  end

  assign confirmed = differ & differ_q;
endmodule

// File: rtl/dcr_recovery_ctrl.sv
module dcr_recovery_ctrl
  import dcr_pkg::*;
#(
  parameter int SETTLE_CYC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      alarm,
  input  logic [1:0]      dead,
  input  logic [1:0]      done,
  input  logic            differ,
  input  logic            confirmed,
  output logic [1:0]      part_req,
  output logic [1:0]      full_req,
  output logic [1:0][1:0] ch_state,
  output logic            fwd_sel,
  output logic            fwd_off,
  output logic            cell_fail,
  output logic            surv_fault
);
  localparam int SC_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(SETTLE_CYC - 1);

  mode_t           mode_q, mode_d;
  logic            fch_q, fch_d;
  logic            kind_q, kind_d;
  logic [SC_W-1:0] scnt_q, scnt_d;
  logic [1:0]      preq_d, freq_d;
  logic            surv;
  logic            surv_bad;
  logic            tgt_ok;
  logic            degraded;

  assign surv     = ~fch_q;
  assign surv_bad = alarm[surv] | dead[surv];
  assign tgt_ok   = ~dead[fch_q] & ~alarm[fch_q] & ~differ;
  assign degraded = (mode_q == M_RECOV) || (mode_q == M_SETTLE) || (mode_q == M_SIMPLEX);

  always_comb begin
    mode_d = mode_q;
    fch_d  = fch_q;
    kind_d = kind_q;
    scnt_d = scnt_q;
    preq_d = 2'b00;
    freq_d = 2'b00;
    case (mode_q)
      M_DUPLEX: begin
        if (alarm[0]) begin
          mode_d = M_RECOV; fch_d = 1'b0; kind_d = 1'b1; freq_d = 2'b01;
        end else if (alarm[1]) begin
          mode_d = M_RECOV; fch_d = 1'b1; kind_d = 1'b1; freq_d = 2'b10;
        end else if (dead[0] & dead[1]) begin
          mode_d = M_FAILED;
        end else if (confirmed & (dead[0] ^ dead[1])) begin
          mode_d = M_RECOV; fch_d = dead[1]; kind_d = 1'b0;
          preq_d = dead[1] ? 2'b10 : 2'b01;
        end
      end
      M_RECOV: begin
        if (surv_bad) mode_d = M_FAILED;
        else if (done[fch_q]) begin
          mode_d = M_SETTLE;
          scnt_d = '0;
        end
      end
      M_SETTLE: begin
        if (surv_bad) mode_d = M_FAILED;
        else if (scnt_q == SC_LAST) mode_d = tgt_ok ? M_DUPLEX : M_SIMPLEX;
        else scnt_d = scnt_q + 1'b1;
      end
      M_SIMPLEX: begin
        if (surv_bad) mode_d = M_FAILED;
      end
      default: mode_d = M_FAILED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_DUPLEX;
      fch_q    <= 1'b0;
      kind_q   <= 1'b0;
      scnt_q   <= '0;
      part_req <= 2'b00;
      full_req <= 2'b00;
    end else begin
      mode_q   <= mode_d;
      fch_q    <= fch_d;
      kind_q   <= kind_d;
      scnt_q   <= scnt_d;
      part_req <= preq_d;
      full_req <= freq_d;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_code
    assign ch_state[i] = code_for(mode_q, 1'(i), fch_q, kind_q);
  end

  assign fwd_sel    = (mode_q == M_DUPLEX) ? 1'b0 : surv;
  assign fwd_off    = (mode_q == M_FAILED);
  assign cell_fail  = (mode_q == M_FAILED);
  assign surv_fault = degraded & surv_bad;
endmodule

// File: rtl/dual_channel_recovery.sv
module dual_channel_recovery
  import dcr_pkg::*;
#(
  parameter int WORD_W       = 8,
  parameter int WDOG_TIMEOUT = 16,
  parameter int SETTLE_CYC   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0][WORD_W-1:0] ch_word,
  input  logic [1:0]             ch_beat,
  input  logic [1:0]             ch_alarm,
  input  logic [1:0]             rcfg_done,
  output logic [WORD_W-1:0]      act_word,
  output logic                   sup_beat,
  output logic [1:0]             part_req,
  output logic [1:0]             full_req,
  output logic [1:0][1:0]        ch_state,
  output logic                   cell_fail
);
  logic [1:0] beat_dead;
  logic       mis_raw;
  logic       mis_hit;
  logic       fwd_sel;
  logic       fwd_off;
  logic       surv_fault;

  for (genvar i = 0; i < 2; i++) begin : g_watch
    dcr_beat_watch #(.WDOG_TIMEOUT(WDOG_TIMEOUT)) u_watch (
      .clk  (clk),
      .rst_n(rst_n),
      .beat (ch_beat[i]),
      .dead (beat_dead[i])
    );
  end

  dcr_skew_filter #(.WORD_W(WORD_W)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_a   (ch_word[0]),
    .word_b   (ch_word[1]),
    .differ   (mis_raw),
    .confirmed(mis_hit)
  );

  dcr_recovery_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .alarm     (ch_alarm),
    .dead      (beat_dead),
    .done      (rcfg_done),
    .differ    (mis_raw),
    .confirmed (mis_hit),
    .part_req  (part_req),
    .full_req  (full_req),
    .ch_state  (ch_state),
    .fwd_sel   (fwd_sel),
    .fwd_off   (fwd_off),
    .cell_fail (cell_fail),
    .surv_fault(surv_fault)
  );

  assign act_word = fwd_off ? '0 : ch_word[fwd_sel];
  assign sup_beat = fwd_off ? 1'b0 : ch_beat[fwd_sel];
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        part_req,
  input logic [1:0]        full_req,
  input logic [1:0][1:0]   ch_state,
  input logic              cell_fail,
  input logic [WORD_W-1:0] act_word,
  input logic              mis_hit,
  input logic              surv_fault
);
  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|{part_req, full_req}) |=> !(|{part_req, full_req}));

  assert_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({part_req, full_req}));

  assert_full_code0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full_req[0] |-> ch_state[0] == 2'd2);

  assert_full_code1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full_req[1] |-> ch_state[1] == 2'd2);

  assert_part_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|part_req) |-> $past(mis_hit));

  assert_lost0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_state[0] == 2'd3) |=> (ch_state[0] == 2'd3));

  assert_lost1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_state[1] == 2'd3) |=> (ch_state[1] == 2'd3));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cell_fail |=> cell_fail);

  assert_fail_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cell_fail |-> (act_word == '0) && (ch_state == 4'hF));

  assert_survivor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    surv_fault |=> cell_fail);
endmodule

bind dual_channel_recovery dcr_checker #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .part_req  (part_req),
  .full_req  (full_req),
  .ch_state  (ch_state),
  .cell_fail (cell_fail),
  .act_word  (act_word),
  .mis_hit   (mis_hit),
  .surv_fault(surv_fault)
);

// File: tb/dual_channel_recovery_tb.sv
module dual_channel_recovery_tb;
  localparam int W   = 8;
  localparam int TO  = 16;
  localparam int SET = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] w0 = '0, w1 = '0;
  logic [1:0]   bt = '0, al = '0, dn = '0;
  bit           ben [2];

  logic [1:0][W-1:0] ch_word;
  logic [W-1:0]      act_word;
  logic              sup_beat, cell_fail;
  logic [1:0]        part_req, full_req;
  logic [1:0][1:0]   ch_state;

  assign ch_word[0] = w0;
  assign ch_word[1] = w1;

  dual_channel_recovery #(.WORD_W(W), .WDOG_TIMEOUT(TO), .SETTLE_CYC(SET)) u_dut (
    .clk(clk), .rst_n(rst_n), .ch_word(ch_word), .ch_beat(bt), .ch_alarm(al),
    .rcfg_done(dn), .act_word(act_word), .sup_beat(sup_beat), .part_req(part_req),
    .full_req(full_req), .ch_state(ch_state), .cell_fail(cell_fail));

  int total = 0, bad = 0;
  int st [2];
  bit mfail, msettle, mmis;
  int mscnt;
  int mcnt [2];
  bit mprev [2];
  bit pq [2], fq [2];
  int npart [2], nfull [2];

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      st[i] = 0; mcnt[i] = 0; mprev[i] = 0; pq[i] = 0; fq[i] = 0;
      npart[i] = 0; nfull[i] = 0;
    end
    mfail = 0; msettle = 0; mmis = 0; mscnt = 0;
  endtask

  task automatic tick();
    bit dd [2];
    bit differ, conf;
    int nst [2];
    bit nfail, nset;
    int nscnt, k, s;
    bit npq [2], nfq [2];
    #1;
    // per-cycle comparison against the model
    check("R2 act_word", int'(act_word), mfail ? 0 : (st[0] == 0 ? int'(w0) : int'(w1)));
    check("R2 sup_beat", int'(sup_beat), mfail ? 0 : (st[0] == 0 ? int'(bt[0]) : int'(bt[1])));
    check("R10 part_req", int'(part_req), int'(pq[1]) * 2 + int'(pq[0]));
    check("R10 full_req", int'(full_req), int'(fq[1]) * 2 + int'(fq[0]));
    check("R8 code ch0", int'(ch_state[0]), st[0]);
    check("R8 code ch1", int'(ch_state[1]), st[1]);
    check("R9 cell_fail", int'(cell_fail), int'(mfail));
    for (int i = 0; i < 2; i++) begin
      if (part_req[i]) npart[i]++;
      if (full_req[i]) nfull[i]++;
    end
    // next model state
    differ = (w0 != w1);
    conf = differ && mmis;
    for (int i = 0; i < 2; i++) begin
      dd[i] = (mcnt[i] == TO);
      nst[i] = st[i]; npq[i] = 0; nfq[i] = 0;
    end
    nfail = mfail; nset = msettle; nscnt = mscnt;
    if (!mfail) begin
      if (st[0] == 0 && st[1] == 0) begin
        if (al[0]) begin nst[0] = 2; nfq[0] = 1; end
        else if (al[1]) begin nst[1] = 2; nfq[1] = 1; end
        else if (dd[0] && dd[1]) begin nfail = 1; nst[0] = 3; nst[1] = 3; end
        else if (conf && (dd[0] != dd[1])) begin
          k = dd[0] ? 0 : 1; nst[k] = 1; npq[k] = 1;
        end
      end else begin
        k = (st[0] != 0) ? 0 : 1;
        s = 1 - k;
        if (al[s] || dd[s]) begin nfail = 1; nst[0] = 3; nst[1] = 3; end
        else if (st[k] != 3) begin
          if (!msettle) begin
            if (dn[k]) begin nset = 1; nscnt = 0; end
          end else if (mscnt == SET - 1) begin
            nset = 0;
            nst[k] = (!dd[k] && !al[k] && !differ) ? 0 : 3;
          end else nscnt = mscnt + 1;
        end
      end
    end
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      if (bt[i] != mprev[i]) mcnt[i] = 0;
      else if (mcnt[i] < TO) mcnt[i]++;
      mprev[i] = bt[i];
      st[i] = nst[i]; pq[i] = npq[i]; fq[i] = nfq[i];
    end
    mmis = differ; mfail = nfail; msettle = nset; mscnt = nscnt;
    @(negedge clk);
    for (int i = 0; i < 2; i++) if (ben[i]) bt[i] = ~bt[i];
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      w0 = w0 + 8'd3; w1 = w0;
      tick();
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; w0 = '0; w1 = '0; bt = '0; al = '0; dn = '0;
    ben[0] = 0; ben[1] = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    ben[0] = 1; ben[1] = 1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    #1;
    check("R1 codes", int'(ch_state), 0);
    check("R1 requests", int'({part_req, full_req}), 0);
    check("R1 cell_fail", int'(cell_fail), 0);
    check("R1 act_word", int'(act_word), int'(w0));
    @(negedge clk);
    run(20);

    // R4 partial path on channel 1, then R7 recovery
    ben[1] = 0; run(20);
    w1 = w0 ^ 8'h55; tick();                 // single-cycle mismatch
    run(3);
    check("R4 single mismatch ignored", int'(ch_state), 0);
    w1 = w0 ^ 8'h0F; tick(); w1 = w0 ^ 8'h0F; tick();
    run(2);
    check("R4 partial pulse ch1", npart[1], 1);
    check("R4 code ch1 partial", int'(ch_state[1]), 1);
    run(4);
    dn[1] = 1; tick(); dn[1] = 0;
    ben[1] = 1; run(SET + 3);
    check("R7 back to duplex", int'(ch_state), 0);

    // R5 mismatch with both heartbeats alive
    for (int i = 0; i < 5; i++) begin w1 = w0 ^ 8'h81; tick(); end
    run(2);
    check("R5 no request", npart[0] + npart[1] + nfull[0] + nfull[1], 1);
    check("R5 codes unchanged", int'(ch_state), 0);

    // R6 alarm and confirmed mismatch in the same cycle on channel 0
    ben[0] = 0; run(20);
    w1 = w0 ^ 8'h3C; tick();
    w1 = w0 ^ 8'h3C; al[0] = 1; tick(); al[0] = 0;
    run(2);
    check("R6 full wins", nfull[0], 1);
    check("R6 no partial ch0", npart[0], 0);
    check("R3 code ch0 full", int'(ch_state[0]), 2);
    // R8 channel 0 stays dead after settle
    dn[0] = 1; tick(); dn[0] = 0;
    run(SET + 3);
    check("R8 ch0 lost", int'(ch_state[0]), 3);
    check("R8 ch1 healthy", int'(ch_state[1]), 0);
    al[0] = 1; w1 = w0 ^ 8'hFF; tick(); tick(); al[0] = 0;
    run(5);
    check("R8 no further request", npart[0] + nfull[0], 1);
    check("R8 still lost", int'(ch_state[0]), 3);
    // R9 survivor heartbeat dies
    ben[1] = 0; run(22);
    check("R9 fail raised", int'(cell_fail), 1);
    check("R9 act zero", int'(act_word), 0);
    ben[1] = 1; run(6);
    check("R9 fail sticky", int'(cell_fail), 1);
    check("R9 codes lost", int'(ch_state), 15);

    // R6 both alarms at once: channel 0 served; R3 full repair then R7
    do_reset();
    run(4);
    al = 2'b11; tick(); al = 2'b00;
    run(2);
    check("R6 ch0 served first", nfull[0], 1);
    check("R6 ch1 untouched", nfull[1], 0);
    check("R3 full code", int'(ch_state[0]), 2);
    dn[0] = 1; tick(); dn[0] = 0;
    run(SET + 2);
    check("R7 full repair returns", int'(ch_state), 0);
    // R9 second fault during recovery
    al[1] = 1; tick(); al[1] = 0;
    run(2);
    check("R3 full pulse ch1", nfull[1], 1);
    al[0] = 1; tick(); al[0] = 0;
    run(2);
    check("R9 second fault fails", int'(cell_fail), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule